// File: doc/BRIEF.md
# Crank-Windowed Airflow Pulse Accumulator

This block turns the pulse train of a frequency-output airflow sensor into a per-cylinder air charge estimate. Each pulse adds a programmable quantum to an interval accumulator. A crank-angle falling edge marks the end of an interval. That edge comes twice per crank revolution, once per cylinder event. On the edge, the accumulated amount becomes the new interval sample and accumulation starts again from zero.

The sample is smoothed by a first-order exponential averager into a 24-bit filtered count, which tracks 256 times the sample. Three load quantities are derived from the upper 16 bits of that count. The first is a scaled air volume, which uses a 16-bit calibration scalar. The second is a saturating 8-bit air volume. The third is a base injector pulse width, which uses an injector factor. A one-cycle strobe marks each new set of results.

Top module: `airflow_accum`

## Requirements
- R1: While reset is low, and after it is released, the filtered count and all derived outputs read zero and the update strobe is low, until the first crank edge has been processed.
- R2: Each cycle with the pulse strobe high adds `quantum_i` to the interval accumulator.
- R3: The interval accumulator saturates at 0xFFFF instead of wrapping.
- R4: A crank strobe takes the accumulator as the interval sample and clears it. A pulse in the same cycle as the crank strobe is counted in the new interval, not in the captured one.
- R5: On update, the filtered count becomes `F + ((256*S - F) >>> k)`. Here F is the old count, S is the sample, and the subtraction is signed and arithmetic. k is `filt_shift_i`, and a value of 0 is treated as 1.
- R6: `air_vol16_o` equals `(air_count_o[23:8] * cal_scalar_i) >> 16`.
- R7: `air_vol8_o` equals `air_vol16_o >> 1` when that value is at most 255, and 0xFF otherwise.
- R8: `inj_pw_o` equals `(air_count_o[23:8] * inj_factor_i) >> 8`, 24 bits wide.
- R9: `update_o` is high for exactly one cycle, two clock edges after the edge that samples the crank strobe. The filtered count changes only on that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_i | input | 1 | Airflow sensor pulse strobe, one cycle per pulse |
| crank_fall_i | input | 1 | Crank-angle falling-edge strobe |
| quantum_i | input | 16 | Amount added per sensor pulse |
| filt_shift_i | input | 3 | Averager shift k (0 behaves as 1) |
| cal_scalar_i | input | 16 | Air volume calibration scalar |
| inj_factor_i | input | 16 | Injector factor |
| air_count_o | output | 24 | Filtered air count |
| air_vol16_o | output | 16 | Scaled air volume |
| air_vol8_o | output | 8 | Halved, saturating air volume |
| inj_pw_o | output | 24 | Base injector pulse width |
| update_o | output | 1 | One-cycle strobe for new outputs |

## Verification
The accumulator and the sample register are hidden. A fault in either one appears as a wrong filtered count on the update cycle after the next crank edge.

The averager is checked with shift 1. From a known count, a single update then moves the output halfway to the target, so an off-by-one in the pulse sum or in the saturation point is visible within one interval.

A pulse that lands in the wrong interval is detected over two crank edges. The second edge follows a pulse-free interval, so it exposes what the first edge left in the accumulator. A bad averager shift or sign shows up as a count that does not match the model after one update.

// File: rtl/airflow_accum.sv
module airflow_accum #(
  parameter int ACC_W   = 16,
  parameter int FRAC_W  = 8,
  parameter int SHIFT_W = 3,
  parameter int COEF_W  = 16,
  parameter int VOL_SH  = 16,
  parameter int PW_SH   = 8,
  parameter int SMALL_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pulse_i,
  input  logic                      crank_fall_i,
  input  logic [ACC_W-1:0]          quantum_i,
  input  logic [SHIFT_W-1:0]        filt_shift_i,
  input  logic [COEF_W-1:0]         cal_scalar_i,
  input  logic [COEF_W-1:0]         inj_factor_i,
  output logic [ACC_W+FRAC_W-1:0]   air_count_o,
  output logic [ACC_W-1:0]          air_vol16_o,
  output logic [SMALL_W-1:0]        air_vol8_o,
  output logic [ACC_W+COEF_W-PW_SH-1:0] inj_pw_o,
  output logic                      update_o
);
  localparam int FILT_W = ACC_W + FRAC_W;
  localparam int PROD_W = ACC_W + COEF_W;
  localparam int PW_W   = PROD_W - PW_SH;
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic [ACC_W-1:0]  acc_q, sample_q;
  logic              cap_q, upd_q;
  logic [FILT_W-1:0] filt_q;

  logic [ACC_W:0]    acc_sum;
  logic [ACC_W-1:0]  acc_sat;
  assign acc_sum = {1'b0, acc_q} + {1'b0, quantum_i};
  assign acc_sat = acc_sum[ACC_W] ? ACC_MAX : acc_sum[ACC_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= '0;
      sample_q <= '0;
      cap_q    <= 1'b0;
    end else begin
      cap_q <= crank_fall_i;
      if (crank_fall_i) begin
        sample_q <= acc_q;
        acc_q    <= pulse_i ? quantum_i : '0;
      end else if (pulse_i) begin
        acc_q <= acc_sat;
      end
    end
  end

  logic [SHIFT_W-1:0]       shamt;
  logic signed [FILT_W+1:0] diff, step, nxt;
  assign shamt = (filt_shift_i == '0) ? SHIFT_W'(1) : filt_shift_i;
  assign diff  = $signed({2'b00, sample_q, {FRAC_W{1'b0}}}) - $signed({2'b00, filt_q});
  assign step  = diff >>> shamt;
  assign nxt   = $signed({2'b00, filt_q}) + step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= cap_q;
      if (cap_q) filt_q <= nxt[FILT_W-1:0];
    end
  end

  logic [ACC_W-1:0]  load_hi;
  logic [PROD_W-1:0] vol_prod, pw_prod;
  assign load_hi  = filt_q[FILT_W-1 -: ACC_W];
  assign vol_prod = PROD_W'(load_hi) * PROD_W'(cal_scalar_i);
  assign pw_prod  = PROD_W'(load_hi) * PROD_W'(inj_factor_i);

  assign air_count_o = filt_q;
  assign air_vol16_o = ACC_W'(vol_prod >> VOL_SH);
  assign inj_pw_o    = PW_W'(pw_prod >> PW_SH);
  assign air_vol8_o  = (air_vol16_o[ACC_W-1:SMALL_W+1] != '0) ? {SMALL_W{1'b1}}
                                                              : air_vol16_o[SMALL_W:1];
  assign update_o    = upd_q;
endmodule

// File: rtl/airflow_accum_chk.sv
module airflow_accum_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        crank_fall_i,
  input logic [23:0] air_count_o,
  input logic [15:0] air_vol16_o,
  input logic [7:0]  air_vol8_o,
  input logic [23:0] inj_pw_o,
  input logic        update_o
);
  // R9: an update is always preceded by a crank strobe two edges earlier
  a_r9_update_follows_crank: assert property (@(posedge clk) disable iff (!rst_n)
    update_o |-> $past(crank_fall_i, 2));

  // R9: the filtered count holds between updates
  a_r9_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !update_o |-> $stable(air_count_o));

  // R7: large scaled volume forces the 8-bit value to its ceiling
  a_r7_small_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (air_vol16_o >= 16'h0200) |-> (air_vol8_o == 8'hFF));

  // R6, R8: no load means no volume and no pulse width
  a_r6_zero_load: assert property (@(posedge clk) disable iff (!rst_n)
    (air_count_o[23:8] == 16'h0) |-> (air_vol16_o == 16'h0 && inj_pw_o == 24'h0));

  // R1: outputs are cleared on the first cycle out of reset
  a_r1_reset_clear: assert property (@(posedge clk)
    (rst_n && $past(!rst_n)) |-> (air_count_o == 24'h0 && !update_o));
endmodule

bind airflow_accum airflow_accum_chk u_chk (
  .clk(clk), .rst_n(rst_n), .crank_fall_i(crank_fall_i),
  .air_count_o(air_count_o), .air_vol16_o(air_vol16_o), .air_vol8_o(air_vol8_o),
  .inj_pw_o(inj_pw_o), .update_o(update_o)
);

// File: tb/airflow_accum_bench.sv
module airflow_accum_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pulse_i = 1'b0;
  logic        crank_fall_i = 1'b0;
  logic [15:0] quantum_i = 16'd0;
  logic [2:0]  filt_shift_i = 3'd1;
  logic [15:0] cal_scalar_i = 16'd0;
  logic [15:0] inj_factor_i = 16'd0;
  logic [23:0] air_count_o;
  logic [15:0] air_vol16_o;
  logic [7:0]  air_vol8_o;
  logic [23:0] inj_pw_o;
  logic        update_o;

  int checks = 0;
  int errors = 0;
  longint m_acc = 0;
  longint m_filt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  airflow_accum u_airflow_accum (
    .clk(clk), .rst_n(rst_n), .pulse_i(pulse_i), .crank_fall_i(crank_fall_i),
    .quantum_i(quantum_i), .filt_shift_i(filt_shift_i), .cal_scalar_i(cal_scalar_i),
    .inj_factor_i(inj_factor_i), .air_count_o(air_count_o), .air_vol16_o(air_vol16_o),
    .air_vol8_o(air_vol8_o), .inj_pw_o(inj_pw_o), .update_o(update_o)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic check_loads(input string req);
    longint hi, v16, v8;
    hi  = m_filt >> 8;
    v16 = (hi * cal_scalar_i) >> 16;
    v8  = (v16 >> 1) > 255 ? 255 : (v16 >> 1);
    check({req, " count"}, air_count_o, m_filt);
    check("R6 air_vol16", air_vol16_o, v16);
    check("R7 air_vol8", air_vol8_o, v8);
    check("R8 inj_pw", inj_pw_o, (hi * inj_factor_i) >> 8);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      pulse_i = 1'b1;
      m_acc = m_acc + quantum_i;
      if (m_acc > 65535) m_acc = 65535;
      @(negedge clk);
    end
    pulse_i = 1'b0;
  endtask

  task automatic crank(input bit with_pulse, input string req);
    longint s, d;
    int k;
    crank_fall_i = 1'b1;
    pulse_i = with_pulse;
    s = m_acc;
    m_acc = with_pulse ? quantum_i : 0;
    @(negedge clk);
    crank_fall_i = 1'b0;
    pulse_i = 1'b0;
    check("R9 no early update", update_o, 0);
    @(negedge clk);
    k = (filt_shift_i == 0) ? 1 : filt_shift_i;
    d = s * 256 - m_filt;
    m_filt = m_filt + (d >>> k);
    check("R9 update high", update_o, 1);
    check_loads(req);
  endtask

  task automatic t_reset;
    check("R1 count", air_count_o, 0);
    check("R1 vol16", air_vol16_o, 0);
    check("R1 vol8", air_vol8_o, 0);
    check("R1 pw", inj_pw_o, 0);
    check("R1 update", update_o, 0);
  endtask

  task automatic t_basic;
    quantum_i = 16'h009C; cal_scalar_i = 16'h5E86; inj_factor_i = 16'h009C;
    filt_shift_i = 3'd1;
    pulses(10);
    repeat (3) @(negedge clk);
    crank(0, "R2 R5 basic");
    check("R2 literal count", air_count_o, 24'h030C00);
    check("R6 literal vol16", air_vol16_o, 288);
    @(negedge clk);
    check("R9 strobe one cycle", update_o, 0);
    check("R9 count holds", air_count_o, m_filt);
  endtask

  task automatic t_coincident;
    quantum_i = 16'h0100;
    pulses(4);
    crank(1, "R4 capture excludes same-cycle pulse");
    repeat (2) @(negedge clk);
    crank(0, "R4 same-cycle pulse in new interval");
  endtask

  task automatic t_saturate;
    quantum_i = 16'hFFFF; cal_scalar_i = 16'hFFFF; inj_factor_i = 16'hFFFF;
    pulses(3);
    crank(0, "R3 saturated interval");
    check("R3 count upper half", air_count_o >= 24'h7FFF80 ? 1 : 0, 1);
    check("R7 vol8 ceiling", air_vol8_o, 8'hFF);
  endtask

  task automatic t_shifts;
    filt_shift_i = 3'd0;
    quantum_i = 16'h0040;
    pulses(2);
    crank(0, "R5 shift zero as one");
    filt_shift_i = 3'd7;
    crank(0, "R5 decay shift seven");
    filt_shift_i = 3'd3;
    cal_scalar_i = 16'h1234; inj_factor_i = 16'h0800;
    for (int j = 0; j < 6; j++) begin
      pulses(5);
      crank(0, "R5 converge shift three");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_coincident();
    t_saturate();
    t_shifts();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule